// File: doc/BRIEF.md
# Debounced Run/Pause Button Toggle

This block turns a raw mechanical push-button into a clean run/pause control for a counter. The button pin is first brought into the clock domain through a chain of flip-flops. A filter then accepts a change of level only after the synchronized input has held that level for a set number of clock cycles, so contact bounce never reaches the control logic. Every accepted press flips a run flag. The run flag serves as the count enable of a counter elsewhere, and that counter holds its value while the flag is low.

The block never touches any count value. Pausing only removes the enable, and the next accepted press restores it, so counting resumes from the held value. A one-cycle press pulse comes out next to the flag for any logic that wants the event itself.

The filter is a state machine with four states. In `DB_IDLE` the button is released and stable. The transition *press seen* leads to `DB_PRESS_WAIT`, which counts stable pressed samples. The transition *press bounced* returns to `DB_IDLE`, and *press accepted* leads to `DB_HELD` and raises the press event. From `DB_HELD`, *release seen* leads to `DB_RELEASE_WAIT`. From there, *release bounced* returns to `DB_HELD` and *release accepted* returns to `DB_IDLE`. The run machine has two states, `RT_RUNNING` and `RT_PAUSED`, and the transition *toggle* on each press event moves between them.

Top module: `btn_run_toggle`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `run_o` is 1 (running) and `press_pulse_o` is 0, and the filter treats the button as released.
- R2: When the pressed level is held steady, `press_pulse_o` is high in the cycle after the (STABLE_CYCLES+2)-th rising clock edge, counting from the first edge that samples the new pin level: two synchronizer stages plus STABLE_CYCLES filter samples.
- R3: A press is accepted only when the synchronized pressed level lasts at least STABLE_CYCLES consecutive cycles. Any shorter pulse or bounce burst produces no press pulse and leaves `run_o` unchanged.
- R4: Each accepted press raises `press_pulse_o` for exactly one cycle, and `run_o` inverts at the same clock edge.
- R5: Holding the button for any length of time and then releasing it produces no further press pulse and no further change of `run_o`.
- R6: A release is accepted only after STABLE_CYCLES consecutive released samples. A release glitch shorter than that, followed by renewed pressing, does not count as a new press.
- R7: `run_o` changes only in a cycle in which `press_pulse_o` is high. With no accepted press the flag holds its value, so a gated counter stays paused at its count or keeps running.
- R8: Parameter BTN_IDLE gives the released level of `btn_raw`, and the pressed level is its inverse. Default 1 gives an active-low button, 0 gives an active-high one. Both polarities behave identically. STABLE_CYCLES must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw | input | 1 | Raw, unsynchronized button pin |
| run_o | output | 1 | Run flag; 1 enables the counter, 0 pauses it |
| press_pulse_o | output | 1 | One-cycle pulse on each accepted press |

## Verification
The hardest case to reach from the ports is a release glitch in the middle of a hold. The filter has to be in `DB_RELEASE_WAIT` when the pin returns to pressed, and it must go back to `DB_HELD` rather than count a second press. The stimulus reaches this case in four steps: it holds the button past the window, releases it for one cycle less than the window, presses again for several windows, and finally releases it for good. It then checks that exactly one pulse occurred. A sweep of pulse widths from one cycle up to past the window finds the exact acceptance threshold. The sweep runs on two instances of opposite polarity that are driven with complementary pins.

// File: rtl/btn_pkg.sv
package btn_pkg;

    typedef enum logic [1:0] {
        DB_IDLE,
        DB_PRESS_WAIT,
        DB_HELD,
        DB_RELEASE_WAIT
    } db_state_t;

    typedef enum logic {
        RT_RUNNING,
        RT_PAUSED
    } rt_state_t;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES   = 2,
    parameter bit BTN_IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic active_o
);

    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= BTN_IDLE;
                    else        chain_q[0] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= BTN_IDLE;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end

        if (BTN_IDLE) begin : g_active_low
            assign active_o = ~chain_q[STAGES-1];
        end else begin : g_active_high
            assign active_o = chain_q[STAGES-1];
        end
    endgenerate

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_q[0] == $past(raw_i)));

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce
    import btn_pkg::*;
#(
    parameter int STABLE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic press_evt_o
);

    localparam int CW = (STABLE_CYCLES > 2) ? $clog2(STABLE_CYCLES) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(STABLE_CYCLES - 1);

    db_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DB_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DB_IDLE: begin
                if (active_i) begin          // press seen
                    st_d  = DB_PRESS_WAIT;
                    cnt_d = CW'(1);
                end
            end
            DB_PRESS_WAIT: begin
                if (!active_i) begin         // press bounced
                    st_d  = DB_IDLE;
                    cnt_d = '0;
                end else if (cnt_q == LIMIT) begin  // press accepted
                    st_d  = DB_HELD;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            DB_HELD: begin
                if (!active_i) begin         // release seen
                    st_d  = DB_RELEASE_WAIT;
                    cnt_d = CW'(1);
                end
            end
            DB_RELEASE_WAIT: begin
                if (active_i) begin          // release bounced
                    st_d  = DB_HELD;
                    cnt_d = '0;
                end else if (cnt_q == LIMIT) begin  // release accepted
                    st_d  = DB_IDLE;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: begin
                st_d  = DB_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        press_evt_o = (st_q == DB_PRESS_WAIT) && active_i && (cnt_q == LIMIT);
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= LIMIT));

    // R3
    press_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DB_PRESS_WAIT && $past(st_q) == DB_PRESS_WAIT)
            |-> (cnt_q == $past(cnt_q) + CW'(1)));

    // R6
    release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DB_IDLE && $past(st_q) == DB_RELEASE_WAIT) |-> !$past(active_i));

endmodule

// File: rtl/run_toggle.sv
module run_toggle
    import btn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press_evt_i,
    output logic run_o,
    output logic pulse_o
);

    rt_state_t st_q, st_d;
    logic      pulse_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= RT_RUNNING;
            pulse_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            pulse_q <= press_evt_i;
        end
    end

    // transitions (toggle)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RT_RUNNING: if (press_evt_i) st_d = RT_PAUSED;
            RT_PAUSED:  if (press_evt_i) st_d = RT_RUNNING;
            default:    st_d = RT_RUNNING;
        endcase
    end

    // outputs
    always_comb begin
        run_o   = (st_q == RT_RUNNING);
        pulse_o = pulse_q;
    end

endmodule

// File: rtl/btn_run_toggle.sv
module btn_run_toggle #(
    parameter int STABLE_CYCLES = 1_000_000,
    parameter int SYNC_STAGES   = 2,
    parameter bit BTN_IDLE      = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_raw,
    output logic run_o,
    output logic press_pulse_o
);

    logic btn_active;
    logic press_evt;

    btn_sync #(
        .STAGES   (SYNC_STAGES),
        .BTN_IDLE (BTN_IDLE)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (btn_raw),
        .active_o (btn_active)
    );

    btn_debounce #(
        .STABLE_CYCLES (STABLE_CYCLES)
    ) filt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (btn_active),
        .press_evt_o (press_evt)
    );

    run_toggle tog_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .press_evt_i (press_evt),
        .run_o       (run_o),
        .pulse_o     (press_pulse_o)
    );

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse_o |=> !press_pulse_o);

    // R4
    pulse_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse_o |-> (run_o != $past(run_o)));

    // R7
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !press_pulse_o |-> $stable(run_o));

    // R1
    reset_run_chk: assert property (@(posedge clk)
        !rst_n |=> (run_o && !press_pulse_o));

endmodule

// File: tb/btn_run_toggle_tb_top.sv
module btn_run_toggle_tb_top;

    localparam int N = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raw_hi = 1'b1;   // idle-high instance pin
    logic raw_lo = 1'b0;   // idle-low instance pin
    logic run_hi, pulse_hi, run_lo, pulse_lo;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int pc_hi = 0, pc_lo = 0;        // pulses seen per instance
    int first_hi = -1, first_lo = -1;
    int dbl = 0;                     // consecutive-pulse events
    bit prev_hi = 0, prev_lo = 0;
    bit exp_run = 1'b1;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    btn_run_toggle #(.STABLE_CYCLES(N), .BTN_IDLE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .btn_raw(raw_hi),
        .run_o(run_hi), .press_pulse_o(pulse_hi));

    btn_run_toggle #(.STABLE_CYCLES(N), .BTN_IDLE(1'b0)) dut_lo_i (
        .clk(clk), .rst_n(rst_n), .btn_raw(raw_lo),
        .run_o(run_lo), .press_pulse_o(pulse_lo));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one negedge: sample outputs, then drive the pin
    task automatic step(input bit pressed);
        @(negedge clk);
        cyc++;
        if (pulse_hi) begin
            pc_hi++;
            if (first_hi < 0) first_hi = cyc;
        end
        if (pulse_lo) begin
            pc_lo++;
            if (first_lo < 0) first_lo = cyc;
        end
        if ((pulse_hi && prev_hi) || (pulse_lo && prev_lo)) dbl++;
        prev_hi = pulse_hi;
        prev_lo = pulse_lo;
        raw_hi = ~pressed;
        raw_lo = pressed;
    endtask

    task automatic hold(input bit pressed, input int n);
        for (int i = 0; i < n; i++) step(pressed);
    endtask

    task automatic clr_counts();
        pc_hi = 0; pc_lo = 0; first_hi = -1; first_lo = -1;
    endtask

    task automatic check_pair(input string tag, input int exp_pulses);
        check(pc_hi == exp_pulses, {tag, " pulses idle-high"}, pc_hi, exp_pulses);
        check(pc_lo == exp_pulses, {tag, " pulses idle-low"}, pc_lo, exp_pulses);
        check(run_hi == exp_run, {tag, " run idle-high"}, run_hi, exp_run);
        check(run_lo == exp_run, {tag, " run idle-low"}, run_lo, exp_run);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(run_hi == 1'b1 && run_lo == 1'b1, "R1 run during reset", run_hi & run_lo, 1);
        check(!pulse_hi && !pulse_lo, "R1 pulse during reset", pulse_hi | pulse_lo, 0);
        rst_n = 1'b1;
        clr_counts();
        hold(1'b0, 3 * N);
        check_pair("R1 idle after reset", 0);

        // R2/R4/R5: steady press, long hold, clean release
        clr_counts();
        step(1'b1);
        begin
            int c0;
            c0 = cyc;
            hold(1'b1, 5 * N);
            check(first_hi == c0 + N + 2, "R2 latency idle-high", first_hi - c0, N + 2);
            check(first_lo == c0 + N + 2, "R2 latency idle-low", first_lo - c0, N + 2);
        end
        exp_run = ~exp_run;
        hold(1'b0, 3 * N);
        check_pair("R5 hold and release", 1);

        // R3/R7/R8: sweep of pulse widths around the window
        for (int w = 1; w <= N + 3; w++) begin
            clr_counts();
            hold(1'b1, w);
            hold(1'b0, 3 * N);
            if (w >= N) exp_run = ~exp_run;
            check_pair($sformatf("R3 width %0d", w), (w >= N) ? 1 : 0);
        end

        // R3: bounce burst before a steady press
        clr_counts();
        hold(1'b1, 2); hold(1'b0, 1); hold(1'b1, 3); hold(1'b0, 2);
        hold(1'b1, N + 5);
        hold(1'b0, 3 * N);
        exp_run = ~exp_run;
        check_pair("R3 bounce then steady", 1);

        // R6: release glitch one short of the window
        clr_counts();
        hold(1'b1, N + 4);
        hold(1'b0, N - 1);
        hold(1'b1, 2 * N);
        hold(1'b0, 3 * N);
        exp_run = ~exp_run;
        check_pair("R6 release glitch", 1);

        // R6: after a full release a new press is accepted
        clr_counts();
        hold(1'b1, N + 4);
        hold(1'b0, 3 * N);
        exp_run = ~exp_run;
        check_pair("R6 press after release", 1);

        // R7: long idle keeps the flag
        clr_counts();
        hold(1'b0, 10 * N);
        check_pair("R7 idle hold", 0);

        // R4: never two pulses back to back
        check(dbl == 0, "R4 one-cycle pulse", dbl, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule